// File: doc/BRIEF.md
# Banked ROM chip-select decoder

This block decodes a 20-bit processor address into chip selects for four 32 KB read-only banks. Together the banks fill the top 128 KB of the address space. It is purely combinational. It takes the full address and the processor's active-low read and write strobes. From these it produces:

- one active-low chip select per bank;
- an output enable shared by all banks;
- the 15-bit offset inside a bank.

A region-hit flag lets the surrounding system tell whether an access fell inside the ROM window. An error flag marks any write aimed at that window.

Three upper address bits qualify the window. The next two address bits feed an enabled 2-to-4 decoder with active-low outputs, so select code n drives bank n. The decoder is enabled only when an access hits the window during a read. A write into the window therefore selects no bank.

Top module: `rom_bank_decode`

## Requirements
- R1: `bank_addr` equals address bits 14..0 for every address and every strobe setting.
- R2: `region_hit` is 1 exactly when address bits 19, 18 and 17 are all 1, which covers 0xE0000 to 0xFFFFF; otherwise it is 0.
- R3: With `region_hit` = 1 and `rd_n` = 0, the bank n whose chip select `bank_cs_n[n]` is low is the value of address bits 16..15, with bit 15 as the least significant bit. Bank 0 spans 0xE0000–0xE7FFF, bank 1 spans 0xE8000–0xEFFFF, bank 2 spans 0xF0000–0xF7FFF and bank 3 spans 0xF8000–0xFFFFF.
- R4: With `region_hit` = 1 and `rd_n` = 0, exactly one bit of `bank_cs_n` is 0.
- R5: With `region_hit` = 0, or with `rd_n` = 1, all four bits of `bank_cs_n` are 1.
- R6: `rom_oe_n` equals `rd_n` at all times.
- R7: `rom_write_err` is 1 exactly when `wr_n` = 0 and `region_hit` = 1. A write with `rd_n` = 1 leaves all chip selects high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr | input | 20 | Processor address |
| rd_n | input | 1 | Processor read strobe, active low |
| wr_n | input | 1 | Processor write strobe, active low |
| bank_cs_n | output | 4 | Per-bank chip selects, active low, bit n for bank n |
| rom_oe_n | output | 1 | Output enable shared by all banks, active low |
| bank_addr | output | 15 | Byte offset within the selected bank |
| region_hit | output | 1 | High when the address lies in the ROM window |
| rom_write_err | output | 1 | High when a write targets the ROM window |

## Verification
The assertions treat the block as settled logic. They assume every input is a known 0 or 1, and they judge outputs only after the inputs have stopped changing.

The bench meets these assumptions. It drives inputs just after a rising clock edge and samples the outputs at the following falling edge, so no sample is taken while inputs are moving. It never drives X or Z.

Every strobe combination is applied to the following addresses:
- the first and last address of each bank;
- the last address below the window and address zero;
- a sweep across all 32 combinations of the five upper address bits.

Both strobes low together is also driven. In that case a read-qualified select and the write error flag are expected at the same time.

// File: rtl/rom_bank_decode.sv
module rom_bank_decode #(
  parameter int ADDR_W  = 20,
  parameter int BANK_AW = 15,
  parameter int SEL_W   = 2
) (
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  rd_n,
  input  logic                  wr_n,
  output logic [(1<<SEL_W)-1:0] bank_cs_n,
  output logic                  rom_oe_n,
  output logic [BANK_AW-1:0]    bank_addr,
  output logic                  region_hit,
  output logic                  rom_write_err
);

  localparam int NBANK  = 1 << SEL_W;
  localparam int TAG_W  = ADDR_W - BANK_AW - SEL_W;
  localparam int TAG_LO = BANK_AW + SEL_W;

  logic [TAG_W-1:0] tag;
  logic [SEL_W-1:0] sel;
  logic             dec_en_n;

  assign tag        = addr[ADDR_W-1:TAG_LO];
  assign sel        = addr[TAG_LO-1:BANK_AW];
  assign bank_addr  = addr[BANK_AW-1:0];
  assign region_hit = &tag;

  assign dec_en_n      = ~(region_hit & ~rd_n);
  assign rom_oe_n      = rd_n;
  assign rom_write_err = region_hit & ~wr_n;

  for (genvar b = 0; b < NBANK; b++) begin : g_dec
    assign bank_cs_n[b] = dec_en_n | (sel != SEL_W'(b));
  end

endmodule

// File: rtl/rom_bank_decode_chk.sv
module rom_bank_decode_chk #(
  parameter int ADDR_W  = 20,
  parameter int BANK_AW = 15,
  parameter int SEL_W   = 2
) (
  input logic [ADDR_W-1:0]     addr,
  input logic                  rd_n,
  input logic                  wr_n,
  input logic [(1<<SEL_W)-1:0] bank_cs_n,
  input logic                  rom_oe_n,
  input logic [BANK_AW-1:0]    bank_addr,
  input logic                  region_hit,
  input logic                  rom_write_err
);

  always_comb begin
    // R1
    offset_pass_chk: assert (bank_addr == addr[BANK_AW-1:0]);
    // R4
    one_cs_chk: assert (!(region_hit && !rd_n) || $countones(~bank_cs_n) == 1);
    // R5
    idle_cs_chk: assert ((region_hit && !rd_n) || &bank_cs_n);
    // R6
    oe_follow_chk: assert (rom_oe_n == rd_n);
    // R7
    wr_err_chk: assert (rom_write_err == (region_hit && !wr_n));
    // R3
    sel_match_chk: assert (!(region_hit && !rd_n) || !bank_cs_n[addr[BANK_AW+SEL_W-1:BANK_AW]]);
  end

endmodule

bind rom_bank_decode rom_bank_decode_chk #(
  .ADDR_W(ADDR_W), .BANK_AW(BANK_AW), .SEL_W(SEL_W)
) u_chk (
  .addr(addr), .rd_n(rd_n), .wr_n(wr_n), .bank_cs_n(bank_cs_n),
  .rom_oe_n(rom_oe_n), .bank_addr(bank_addr), .region_hit(region_hit),
  .rom_write_err(rom_write_err)
);

// File: tb/rom_bank_decode_tb.sv
module rom_bank_decode_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [19:0] addr = '0;
  logic        rd_n = 1'b1;
  logic        wr_n = 1'b1;
  logic [3:0]  bank_cs_n;
  logic        rom_oe_n;
  logic [14:0] bank_addr;
  logic        region_hit;
  logic        rom_write_err;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  rom_bank_decode u_dut (
    .addr(addr), .rd_n(rd_n), .wr_n(wr_n), .bank_cs_n(bank_cs_n),
    .rom_oe_n(rom_oe_n), .bank_addr(bank_addr), .region_hit(region_hit),
    .rom_write_err(rom_write_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s addr=%05h rd_n=%0b wr_n=%0b actual=%0h expected=%0h",
               req, addr, rd_n, wr_n, act, exp);
    end
  endtask

  task automatic apply(input logic [19:0] a, input logic r, input logic w);
    int hit, bank;
    logic [3:0] exp_cs;
    @(posedge clk);
    addr = a; rd_n = r; wr_n = w;
    @(negedge clk);
    hit    = (a >= 20'hE0000) ? 1 : 0;
    bank   = hit ? int'((a - 20'hE0000) / 20'h08000) : 0;
    exp_cs = 4'hF;
    if (hit == 1 && r == 1'b0) exp_cs[bank] = 1'b0;
    chk("R1", int'(bank_addr), int'(a % 20'h08000));
    chk("R2", int'(region_hit), hit);
    if (hit == 1 && r == 1'b0) begin
      chk("R3", int'(bank_cs_n), int'(exp_cs));
      chk("R4", $countones(~bank_cs_n), 1);
    end else begin
      chk("R5", int'(bank_cs_n), 15);
    end
    chk("R6", int'(rom_oe_n), int'(r));
    chk("R7", int'(rom_write_err), (hit == 1 && w == 1'b0) ? 1 : 0);
  endtask

  task automatic all_strobes(input logic [19:0] a);
    for (int s = 0; s < 4; s++) apply(a, s[0], s[1]);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R5", int'(bank_cs_n), 15);
    chk("R6", int'(rom_oe_n), 1);
    chk("R7", int'(rom_write_err), 0);
    for (int b = 0; b < 4; b++) begin
      all_strobes(20'hE0000 + 20'(b) * 20'h08000);
      all_strobes(20'hE0000 + 20'(b) * 20'h08000 + 20'h07FFF);
    end
    all_strobes(20'hDFFFF);
    all_strobes(20'h00000);
    for (int u = 0; u < 32; u++) begin
      all_strobes({u[4:0], 15'h2A55});
      all_strobes({u[4:0], 15'h55AA});
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule